// File: doc/BRIEF.md
# Timed Peak Current Limit Selector

This block decides which of two peak switch-current thresholds a boost converter's current comparator uses: the nominal level (2 A), chosen by default, or a raised level (2.5 A). A qualified limit hit in the ready state moves the threshold to the raised level for a fixed window, which lets a warm start ride through its inrush without tripping. After the raised window ends, the nominal level is forced for an equal window, and no hit can raise the threshold during it. Under a continuing overload the block therefore alternates nominal and raised windows of equal length, giving a period of two windows.

The limit-hit input comes from an analog comparator through a synchronizer. It counts only after it has stayed high for a set number of consecutive clocks, so single-cycle comparator noise is rejected. Long intervals are measured in ticks of a prescaled strobe (1 ms per tick by default, so a 1.5 s window is 1500 ticks). A sustained-overload flag reports back-to-back raises. It clears once the hit input has been quiet for two full windows.

Top module: `curlim_ctrl`

## Requirements
- R1: During and after reset, `thr_sel_o` is 0 and `overload_o` is 0. `thr_sel_o` uses 0 for the nominal (2 A) threshold and 1 for the raised (2.5 A) threshold.
- R2: A limit hit counts only when `hit_i` has been high for FILT_LEN (default 2) consecutive clocks. A one-clock pulse, or separate one-clock pulses, never change `thr_sel_o`.
- R3: In the ready state, a qualified hit raises the threshold. When `hit_i` is high for exactly two clocks, `thr_sel_o` becomes 1 on the third rising edge counted from the first edge that samples `hit_i` high.
- R4: The raised threshold stays selected for exactly WIN_TICKS ticks sampled while raised. `thr_sel_o` then returns to 0.
- R5: After a raised window, the nominal threshold is held for exactly WIN_TICKS ticks, even if `hit_i` stays high the whole time.
- R6: Under an overload that does not stop, the block keeps alternating raised and nominal windows of WIN_TICKS ticks each.
- R7: `overload_o` rises on the same edge as `thr_sel_o` when a raise starts at the very edge where a nominal hold window ends.
- R8: `overload_o` clears after 2*WIN_TICKS ticks sampled with no qualified hit. Any qualified hit restarts this count.
- R9: A single isolated raise, followed by a hold window with no hit, leaves `overload_o` at 0 and leaves the block ready at the nominal level.
- R10: Reset applied in the middle of operation returns `thr_sel_o` and `overload_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock strobe from the prescaler, one per timing unit |
| hit_i | input | 1 | Synchronized limit-hit flag from the current comparator |
| thr_sel_o | output | 1 | Threshold select: 0 nominal, 1 raised |
| overload_o | output | 1 | Sustained-overload status |

## Verification
A qualified hit appears two edges after `hit_i` is first sampled high. The threshold changes one edge after that, so `thr_sel_o` is due on the third edge. The bench checks the cycle before that edge and the cycle after it. Every window boundary and the overload clear take effect one edge after the tick that ends the count. The bench drives `tick_i` and `hit_i` just after the falling edge, reads the outputs there, and counts the ticks that are about to be consumed while each output holds its level. It then compares that tick count with WIN_TICKS or 2*WIN_TICKS.

// File: rtl/curlim_pkg.sv
package curlim_pkg;
  typedef enum logic [1:0] {
    ST_READY  = 2'd0,
    ST_RAISED = 2'd1,
    ST_HOLD   = 2'd2
  } lim_state_t;
endpackage

// File: rtl/curlim_hit_filter.sv
module curlim_hit_filter #(
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  output logic qual_o
);
  localparam int RW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [RW-1:0] RUN_TOP = RW'(FILT_LEN - 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      qual_o <= 1'b0;
    end else begin
      if (!hit_i)
        run_q <= '0;
      else if (run_q != RUN_TOP)
        run_q <= run_q + 1'b1;
      qual_o <= hit_i && (run_q == RUN_TOP);
    end
  end

  // R2: a qualified hit always follows a sampled high input
  assert_qual_needs_hit_R2: assert property (@(posedge clk) disable iff (rst)
    qual_o |-> $past(hit_i));
endmodule

// File: rtl/curlim_window_timer.sv
module curlim_window_timer #(
  parameter int WIN_TICKS = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(WIN_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = tick_i && !clr_i && (cnt_q == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt_q <= '0;
    else if (tick_i)
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  // R4: the window count never passes its last value
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_TOP);
endmodule

// File: rtl/curlim_overload_mon.sv
module curlim_overload_mon #(
  parameter int CLR_TICKS = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic qual_i,
  input  logic tick_i,
  output logic ovl_o
);
  localparam int QW = (CLR_TICKS > 1) ? $clog2(CLR_TICKS) : 1;
  localparam logic [QW-1:0] QUIET_TOP = QW'(CLR_TICKS - 1);

  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_o   <= 1'b0;
      quiet_q <= '0;
    end else if (set_i) begin
      ovl_o   <= 1'b1;
      quiet_q <= '0;
    end else if (!ovl_o || qual_i) begin
      quiet_q <= '0;
    end else if (tick_i) begin
      if (quiet_q == QUIET_TOP) begin
        ovl_o   <= 1'b0;
        quiet_q <= '0;
      end else begin
        quiet_q <= quiet_q + 1'b1;
      end
    end
  end

  // R8: the flag drops only on a quiet tick
  assert_clear_on_quiet_tick_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ovl_o) |-> ($past(tick_i) && !$past(qual_i)));
endmodule

// File: rtl/curlim_ctrl.sv
module curlim_ctrl #(
  parameter int FILT_LEN  = 2,
  parameter int WIN_TICKS = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic hit_i,
  output logic thr_sel_o,
  output logic overload_o
);
  import curlim_pkg::*;

  localparam int CLR_TICKS = 2 * WIN_TICKS;

  lim_state_t state_q, state_d;
  logic       qual;
  logic       win_done;
  logic       ovl_set;

  curlim_hit_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .hit_i(hit_i), .qual_o(qual)
  );

  curlim_window_timer #(.WIN_TICKS(WIN_TICKS)) u_win (
    .clk(clk), .rst(rst), .clr_i(state_q == ST_READY),
    .tick_i(tick_i), .done_o(win_done)
  );

  always_comb begin
    state_d = state_q;
    ovl_set = 1'b0;
    unique case (state_q)
      ST_READY:  if (qual) state_d = ST_RAISED;
      ST_RAISED: if (win_done) state_d = ST_HOLD;
      ST_HOLD: begin
        if (win_done) begin
          state_d = qual ? ST_RAISED : ST_READY;
          ovl_set = qual;
        end
      end
      default:   state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_READY;
      thr_sel_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      thr_sel_o <= (state_d == ST_RAISED);
    end
  end

  curlim_overload_mon #(.CLR_TICKS(CLR_TICKS)) u_ovl (
    .clk(clk), .rst(rst), .set_i(ovl_set), .qual_i(qual),
    .tick_i(tick_i), .ovl_o(overload_o)
  );

  // R3: a raise is always caused by a qualified hit
  assert_raise_needs_qual_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(thr_sel_o) |-> $past(qual));
  // R4: the raised window ends only on the closing tick
  assert_drop_on_window_end_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(thr_sel_o) |-> $past(win_done));
  // R5: no raise while the hold window runs
  assert_no_raise_in_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && !win_done) |=> !thr_sel_o);
  // R7: overload appears together with a raise
  assert_overload_with_raise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(overload_o) |-> thr_sel_o);
endmodule

// File: tb/curlim_ctrl_bench.sv
module curlim_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN   = 6;
  localparam int TDIV  = 4;
  localparam int WDOG  = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic hit = 1'b0;
  logic thr_sel, ovl;
  int   n_chk = 0;
  int   n_err = 0;
  int   div = 0;

  curlim_ctrl #(.FILT_LEN(2), .WIN_TICKS(WIN)) u_curlim_ctrl (
    .clk(clk), .rst(rst), .tick_i(tick), .hit_i(hit),
    .thr_sel_o(thr_sel), .overload_o(ovl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    div  <= (div == TDIV-1) ? 0 : div + 1;
    tick <= (div == TDIV-1);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  // counts ticks consumed while thr_sel keeps its present level
  task automatic count_sel(input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      if (thr_sel != lvl) break;
      if (tick) n++;
      step(1);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; step(3);
    chk("R1 sel in reset", thr_sel, 0);
    chk("R1 ovl in reset", ovl, 0);
    rst = 1'b0; step(2);
    chk("R1 sel after reset", thr_sel, 0);
    chk("R1 ovl after reset", ovl, 0);
  endtask

  task automatic t_glitch;
    hit = 1'b1; step(1); hit = 1'b0; step(1);
    hit = 1'b1; step(1); hit = 1'b0; step(20);
    chk("R2 one-clock pulses ignored", thr_sel, 0);
  endtask

  task automatic t_single;
    int n;
    hit = 1'b1; step(2); hit = 1'b0;
    chk("R3 not yet raised after two edges", thr_sel, 0);
    step(1);
    chk("R3 raised on third edge", thr_sel, 1);
    count_sel(1'b1, n);
    chk("R4 raised window ticks", n, WIN);
    chk("R9 no overload after single raise", ovl, 0);
    step(WIN * TDIV * 3);
    chk("R9 back at nominal", thr_sel, 0);
    chk("R9 overload still low", ovl, 0);
  endtask

  task automatic t_persist;
    int n;
    hit = 1'b1;
    for (int i = 0; i < 10 && !thr_sel; i++) step(1);
    chk("R3 raise under steady hit", thr_sel, 1);
    count_sel(1'b1, n);
    chk("R4 first raised window", n, WIN);
    count_sel(1'b0, n);
    chk("R5 hold window despite hit", n, WIN);
    chk("R7 overload rises with raise", ovl, 1);
    count_sel(1'b1, n);
    chk("R6 second raised window", n, WIN);
    count_sel(1'b0, n);
    chk("R6 second hold window", n, WIN);
    chk("R6 raised again", thr_sel, 1);
  endtask

  task automatic t_clear;
    int n = 0;
    hit = 1'b0;
    step(1);
    for (int i = 0; i < 2000; i++) begin
      if (!ovl) break;
      if (tick) n++;
      step(1);
    end
    chk("R8 quiet ticks to clear", n, 2 * WIN);
    step(WIN * TDIV * 3);
    chk("R8 nominal after clear", thr_sel, 0);
  endtask

  task automatic t_reset_mid;
    hit = 1'b1;
    for (int i = 0; i < 2000 && !ovl; i++) step(1);
    chk("R10 overload before reset", ovl, 1);
    rst = 1'b1; hit = 1'b0; step(2);
    rst = 1'b0; step(1);
    chk("R10 sel after mid reset", thr_sel, 0);
    chk("R10 ovl after mid reset", ovl, 0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_glitch();
    t_single();
    t_persist();
    t_clear();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=done", WDOG);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule